// File: doc/BRIEF.md
# Packet Header Parser and Reflector

This block takes a byte-wide valid/ready stream of packets, each made of a fixed 20-byte header and a payload whose size is given by a 16-bit length field in the header. It keeps track of the header byte index and counts payload bytes, so it always knows where a packet ends and where the next header begins. Complete packets that pass the length and space checks go into an internal byte store. Rejected packets are consumed and thrown away, and a one-cycle flag reports why.

When the `drain` input is high and the parser sits between packets, the block sends the buffered packets out on a second valid/ready stream. The newest packet leaves first. Each outgoing packet has its two 16-bit address fields exchanged, so the reply goes back to the sender. Every other byte leaves exactly as it arrived. Input is held off while a packet is being sent out.

Header layout, by byte index: 0 command; 1–2 sender address; 3–4 target address; 5–8 packet identifier; 9–16 reserved; 17 check byte; 18–19 payload length. Every multi-byte field is sent most significant byte first.

Top module: `pkt_reflector`

## Requirements
- R1: Input bytes are grouped into a 20-byte header followed by a payload. The length is byte 18 (high byte) and byte 19 (low byte) of the header.
- R2: In every outgoing packet, bytes 1–2 carry the incoming bytes 3–4, and bytes 3–4 carry the incoming bytes 1–2, each pair keeping its byte order.
- R3: Header bytes 0 and 5–19, and all payload bytes, go out unchanged and in their original order. This includes the check byte, the reserved field and the length.
- R4: A packet ends after exactly 20 + length bytes. The next accepted byte is byte 0 of a new header, even after a dropped packet.
- R5: Replay happens only while `drain` is high and the parser is between packets. Stored packets are sent out newest first.
- R6: `in_ready` is low in every cycle in which `out_valid` is high.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` keep their values in the next cycle.
- R8: `out_last` is high only on the final byte of each outgoing packet. That is the last payload byte, or header byte 19 when the length is zero.
- R9: If the length is greater than MAXP, the packet is consumed but not stored. `err_len` is high for exactly the one cycle after the edge that accepts byte 19.
- R10: If a packet's 20 + length bytes do not fit in the free store space, or all PKTS slots are taken, the whole packet is discarded. `err_ovf` is high for exactly the one cycle after the edge that accepts byte 19.
- R11: A packet cannot be sent out until its final byte has been accepted, even if `drain` is already high.
- R12: A synchronous `rst` empties the store and clears the parser. After reset, `out_valid`, `err_len` and `err_ovf` are low, and the next accepted byte is header byte 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block accepts an input byte |
| in_data | input | 8 | Input byte |
| drain | input | 1 | Request to send out the stored packets |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Receiver accepts the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Final byte of the outgoing packet |
| err_len | output | 1 | One-cycle pulse: length above MAXP |
| err_ovf | output | 1 | One-cycle pulse: no room for the packet |

## Verification
The error flags are registered. They are due one cycle after the edge that accepts header byte 19, so the bench samples them at the falling edge right after that byte is taken. Output bytes come straight from the store. A rising `drain` at a packet boundary makes `out_valid` rise at the second falling edge, that is, one register stage later. The bench sets `out_ready` at each falling edge, records a byte only when valid and ready were both high at that moment, and checks R7 at the following falling edge. Each replayed packet is compared with a model stack that holds the accepted packets.

// File: rtl/pkt_reflector.sv
module pkt_reflector #(
  parameter int DEPTH = 256,
  parameter int PKTS  = 4,
  parameter int MAXP  = 64
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       in_valid,
  output logic       in_ready,
  input  logic [7:0] in_data,
  input  logic       drain,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_data,
  output logic       out_last,
  output logic       err_len,
  output logic       err_ovf
);
  localparam int HDR = 20;
  localparam int IW  = $clog2(DEPTH);
  localparam int AW  = IW + 1;
  localparam int SW  = $clog2(PKTS + 1);
  localparam logic [4:0] HLAST = 5'(HDR - 1);
  localparam logic [4:0] HLEN  = 5'(HDR - 2);

  logic [7:0]    mem    [DEPTH];
  logic [AW-1:0] starts [1 << SW];
  logic [AW-1:0] top, wptr, rptr, rbeg, rend;
  logic [SW-1:0] sp;
  logic [4:0]    hidx;
  logic          in_pay, keep, rp_act;
  logic [7:0]    lenhi;
  logic [15:0]   rem;

  wire bound = !in_pay && hidx == 5'd0;
  wire go    = !rp_act && drain && bound && sp != '0;
  assign in_ready = !rp_act && !go;
  wire acc = in_valid && in_ready;

  wire [AW-1:0] cur = bound ? top : wptr;
  wire [15:0]   len = {lenhi, in_data};
  wire len_bad = 32'(len) > MAXP;
  wire fits    = 32'(sp) < PKTS && (32'(top) + 32'(len) + HDR) <= DEPTH;
  wire hdr_end = acc && !in_pay && hidx == HLAST;
  wire pay_end = acc && in_pay && rem == 16'd1;
  wire commit  = (hdr_end && len == 16'd0 && fits) || (pay_end && keep);
  wire wr_en   = acc && (in_pay ? keep : 32'(cur) < DEPTH);

  wire [AW-1:0] pos = rptr - rbeg;
  wire [AW-1:0] raddr = (32'(pos) == 1 || 32'(pos) == 2) ? rptr + AW'(2) :
                        (32'(pos) == 3 || 32'(pos) == 4) ? rptr - AW'(2) : rptr;
  assign out_valid = rp_act;
  assign out_data  = mem[raddr[IW-1:0]];
  assign out_last  = rp_act && (rptr + 1'b1 == rend);

  always_ff @(posedge clk) begin
    if (wr_en) mem[cur[IW-1:0]] <= in_data;
    if (commit) starts[sp] <= top;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hidx <= '0; in_pay <= 1'b0; keep <= 1'b0; lenhi <= '0; rem <= '0;
      wptr <= '0; top <= '0; sp <= '0; rp_act <= 1'b0;
      rptr <= '0; rbeg <= '0; rend <= '0;
      err_len <= 1'b0; err_ovf <= 1'b0;
    end else begin
      err_len <= 1'b0;
      err_ovf <= 1'b0;
      if (acc) begin
        if (!in_pay) begin
          wptr <= cur + 1'b1;
          if (hidx == HLEN) lenhi <= in_data;
          if (hidx == HLAST) begin
            hidx    <= '0;
            err_len <= len_bad;
            err_ovf <= !len_bad && !fits;
            keep    <= !len_bad && fits;
            in_pay  <= len != 16'd0;
            rem     <= len;
          end else begin
            hidx <= hidx + 1'b1;
          end
        end else begin
          if (keep) wptr <= wptr + 1'b1;
          rem <= rem - 1'b1;
          if (rem == 16'd1) in_pay <= 1'b0;
        end
      end
      if (commit) begin
        sp  <= sp + 1'b1;
        top <= cur + 1'b1;
      end
      if (go) begin
        rp_act <= 1'b1;
        rptr   <= starts[sp - 1'b1];
        rbeg   <= starts[sp - 1'b1];
        rend   <= top;
      end else if (rp_act && out_ready) begin
        if (out_last) begin
          rp_act <= 1'b0;
          top    <= rbeg;
          sp     <= sp - 1'b1;
        end else begin
          rptr <= rptr + 1'b1;
        end
      end
    end
  end
endmodule

module pkt_reflector_chk (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic [7:0] in_data,
  input logic       drain,
  input logic       out_valid,
  input logic       out_ready,
  input logic [7:0] out_data,
  input logic       out_last,
  input logic       err_len,
  input logic       err_ovf
);
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R7
  AST_IN_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready); // R6
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid); // R8
  AST_LEN_PULSE: assert property (@(posedge clk) disable iff (rst)
    err_len |=> !err_len); // R9
  AST_OVF_PULSE: assert property (@(posedge clk) disable iff (rst)
    err_ovf |=> !err_ovf); // R10
  AST_ONE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    !(err_len && err_ovf)); // R10
  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> !out_valid && !err_len && !err_ovf); // R12
endmodule

bind pkt_reflector pkt_reflector_chk chk (.*);

// File: tb/pkt_reflector_test.sv
module pkt_reflector_test;
  localparam int DEPTH = 128;
  localparam int PKTS  = 4;
  localparam int MAXP  = 40;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, drain = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, out_last, err_len, err_ovf;
  logic [7:0] out_data;

  int tests = 0, fails = 0;
  logic [7:0] mmem[$];
  int mst[$];

  always #10 clk = ~clk;

  pkt_reflector #(.DEPTH(DEPTH), .PKTS(PKTS), .MAXP(MAXP)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .drain(drain), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .err_len(err_len), .err_ovf(err_ovf));

  task automatic chk(bit ok, string req, string what, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int src_pos(int p);
    if (p == 1 || p == 2) return p + 2;
    if (p == 3 || p == 4) return p - 2;
    return p;
  endfunction

  task automatic put(logic [7:0] b);
    in_valid = 1'b1;
    in_data  = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // sends one packet; checks R9/R10 flags after byte 19; updates model
  task automatic send_pkt(int len, bit watch_out);
    logic [7:0] b[$];
    bit lerr, ovf;
    for (int i = 0; i < 20 + len; i++) b.push_back(8'($urandom));
    b[18] = len[15:8];
    b[19] = len[7:0];
    lerr = len > MAXP;
    ovf  = !lerr && (mst.size() >= PKTS || mmem.size() + 20 + len > DEPTH);
    for (int i = 0; i < b.size(); i++) begin
      put(b[i]);
      if (i == 19) begin
        chk(err_len == lerr, "R9", "err_len after length byte", int'(err_len), int'(lerr));
        chk(err_ovf == ovf, "R10", "err_ovf after length byte", int'(err_ovf), int'(ovf));
      end
      if (watch_out && i < b.size() - 1)
        chk(!out_valid, "R11", "out_valid before packet end", int'(out_valid), 0);
    end
    if (!lerr && !ovf) begin
      mst.push_back(mmem.size());
      for (int i = 0; i < b.size(); i++) mmem.push_back(b[i]);
    end
  endtask

  // replay everything in the model (R5 newest first), check R2 R3 R6 R7 R8
  task automatic drain_all();
    bit stall = 1'b0;
    logic [7:0] pd;
    logic pl;
    drain = 1'b1;
    while (mst.size() > 0) begin
      int s, n, got;
      logic [7:0] exp[$];
      s = mst.pop_back();
      n = mmem.size() - s;
      for (int p = 0; p < n; p++) exp.push_back(mmem[s + src_pos(p)]);
      got = 0;
      while (got < n) begin
        @(negedge clk);
        if (stall)
          chk(out_valid && out_data == pd && out_last == pl, "R7", "held output byte",
              int'(out_data), int'(pd));
        if (out_valid && in_ready) chk(1'b0, "R6", "in_ready while sending", 1, 0);
        out_ready = ($urandom % 4) != 0;
        if (out_valid) begin
          stall = !out_ready;
          pd = out_data;
          pl = out_last;
          if (out_ready) begin
            chk(out_data == exp[got], (got >= 1 && got <= 4) ? "R2" : "R3",
                "output byte value", int'(out_data), int'(exp[got]));
            chk(out_last == (got == n - 1), "R8", "out_last position",
                int'(out_last), int'(got == n - 1));
            got++;
          end
        end else begin
          stall = 1'b0;
        end
      end
      while (mmem.size() > s) void'(mmem.pop_back());
    end
    @(negedge clk);
    drain = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R5", "no output once store is empty", int'(out_valid), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(!out_valid && in_ready && !err_len && !err_ovf, "R12", "state after reset",
        int'({out_valid, in_ready, err_len, err_ovf}), 4);

    // R1 R8: zero length packet, last flag on header byte 19
    send_pkt(0, 1'b0);
    drain_all();

    // R5: three packets come back newest first
    send_pkt(3, 1'b0);
    send_pkt(0, 1'b0);
    send_pkt(7, 1'b0);
    drain_all();

    // R11: drain high while packet still arriving
    drain = 1'b1;
    send_pkt(5, 1'b1);
    drain_all();

    // R9 R4: oversize length dropped, framing resumes with next packet
    send_pkt(MAXP + 1, 1'b0);
    send_pkt(MAXP, 1'b0);
    drain_all();

    // R10: byte space exhausted, then slot count exhausted
    send_pkt(MAXP, 1'b0);
    send_pkt(MAXP, 1'b0);
    send_pkt(0, 1'b0);
    drain_all();
    for (int i = 0; i < PKTS + 1; i++) send_pkt(0, 1'b0);
    drain_all();

    // R12: reset empties the store
    send_pkt(4, 1'b0);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mmem.delete();
    mst.delete();
    drain = 1'b1;
    repeat (5) @(negedge clk);
    chk(!out_valid, "R12", "no replay after reset", int'(out_valid), 0);
    drain = 1'b0;
    send_pkt(2, 1'b0);
    drain_all();

    // random rounds
    for (int r = 0; r < 40; r++) begin
      int k = 1 + $urandom % 5;
      for (int j = 0; j < k; j++) send_pkt($urandom % (MAXP + 6), 1'b0);
      drain_all();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule